// File: doc/BRIEF.md
# Clock Mode Controller

This unit keeps the clock configuration of a small telephony controller and turns it into two results. The first is the divisor to apply to the crystal input before the PLL. The second is a one-hot set of clock enables that picks the microcontroller clock. That clock is either the free-running emergency clock or one of four clocks derived from the PLL. Software programs two small registers through a plain write port and reads them back, with a status word, through a combinational read port. All pins are control and status pins, so no valid/ready handshake is used. A write takes effect at the clock edge where `wr_en` is high, and it cannot be stalled.

The unit protects the processor from losing its clock. It refuses to leave the emergency clock unless the PLL is enabled and locked. If software turns the PLL off while a PLL clock is in use, the unit first moves the processor back to the emergency clock and only then drops the PLL enable. Each change of source drops the old enable, leaves one cycle with no enable active, and then raises the new enable. This prevents runt pulses.

It also decodes the input-frequency settings. For the 3.58 MHz crystal setting it raises a frequency-correction flag. The same setting forces the serial peripheral interface into master-only operation.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset, CTL (address 0) reads 0, SYS (address 1) reads 0, status (address 2) reads 0, `clk_en` is 5'b00001 (emergency clock), `prediv_ratio` is 1, `freq_corr`, `iom_master_only` and `pll_en_o` are 0.
- R2: `prediv_ratio` gives the divisor as a number, decoded from SYS bits [2:1] (input select) while CTL bit 1 is 0. Select 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 1.
- R3: When CTL bit 1 (3.58 MHz mode) is 1 and the input select is 00, `freq_corr` and `iom_master_only` are 1 and the ratio is 1. When CTL bit 1 is 1 with any other input select, the ratio is 1 and both flags are 0.
- R4: While CTL bit 0 (run-from-PLL) is 0, the only enable is `clk_en[0]`, the emergency clock, whatever CTL bits [3:2] hold.
- R5: While CTL bit 0 is 1, micro-clock select CTL[3:2] = 00, 01, 10, 11 enables `clk_en[1]`, `[2]`, `[3]`, `[4]` respectively.
- R6: A CTL write that would set bit 0 while it is 0 is rejected if SYS bit 0 (PLL enable) is 0, if `pll_lock` is low, or if a PLL shutdown is pending. CTL bit 0 stays 0, the other CTL fields are still written, and the sticky error (status bit 4) is set.
- R7: A SYS write with bit 0 = 0 clears CTL bit 0 at once. The input select is applied at once. `pll_en_o` stays 1 until the emergency enable is active again and drops one cycle later. A PLL-derived enable is never active while `pll_en_o` is 0.
- R8: A source change drops the old enable one cycle after the new target is registered. All enables stay low for exactly one cycle, and the new enable rises in the next cycle. At most one enable is ever active.
- R9: Status (address 2) reads {err, gap, src[2:0]}, where src is 0 for the emergency clock and 1 to 4 for the PLL clocks, and gap is 1 during the idle cycle.
- R10: Once set, the error flag stays set until reset. With the PLL enabled and locked, a write that sets CTL bit 0 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 CTL, 1 SYS) |
| wr_data | input | 4 | Write data |
| rd_addr | input | 2 | Read address (0 CTL, 1 SYS, 2 status) |
| rd_data | output | 5 | Read data, combinational |
| pll_lock | input | 1 | PLL lock indication |
| pll_en_o | output | 1 | PLL enable to the analog PLL |
| prediv_ratio | output | 3 | Input pre-divider ratio (1, 2 or 4) |
| freq_corr | output | 1 | 3.58 MHz frequency correction needed |
| iom_master_only | output | 1 | Force the peripheral serial interface to master mode |
| clk_en | output | 5 | One-hot microcontroller clock enables, bit 0 emergency |

## Verification
Register fields, `prediv_ratio`, `freq_corr` and `iom_master_only` are due one edge after the write. The bench therefore checks them at the falling edge that ends the write task. `clk_en` goes to zero at the second falling edge after the write, and the new enable appears at the third. During a PLL shutdown, `pll_en_o` falls at the fourth falling edge. Each scenario task steps through those falling edges one at a time and samples there, so every expected value is compared in the cycle it is due and never after it has settled.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_SYS  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef enum logic {SW_STEADY = 1'b0, SW_GAP = 1'b1} sw_state_e;

  typedef struct packed {
    logic [2:0] ratio;
    logic       corr;
  } prediv_t;
endpackage

// File: rtl/clkmode_prediv.sv
module clkmode_prediv
  import clkmode_pkg::*;
(
  input  logic       xtal358,
  input  logic [1:0] in_sel,
  output prediv_t    res
);
  always_comb begin
    res = '{ratio: 3'd1, corr: 1'b0};
    unique case ({xtal358, in_sel})
      3'b000: res.ratio = 3'd1;
      3'b100: res = '{ratio: 3'd1, corr: 1'b1};
      3'b001: res.ratio = 3'd2;
      3'b010: res.ratio = 3'd4;
      default: res.ratio = 3'd1;
    endcase
  end
endmodule

// File: rtl/clkmode_regs.sv
module clkmode_regs
  import clkmode_pkg::*;
#(
  parameter int WW     = 4,
  parameter int USEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WW-1:0]     wr_data,
  input  logic              pll_lock,
  input  logic              settled_emg,
  output logic              leave_q,
  output logic              xtal_q,
  output logic [USEL_W-1:0] usel_q,
  output logic              pll_en_q,
  output logic [1:0]        in_sel_q,
  output logic              err_q
);
  logic off_pend_q;
  logic set_blocked;

  assign set_blocked = !pll_en_q || !pll_lock || off_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leave_q    <= 1'b0;
      xtal_q     <= 1'b0;
      usel_q     <= '0;
      pll_en_q   <= 1'b0;
      in_sel_q   <= 2'b00;
      err_q      <= 1'b0;
      off_pend_q <= 1'b0;
    end else begin
      if (off_pend_q && settled_emg) begin
        pll_en_q   <= 1'b0;
        off_pend_q <= 1'b0;
      end
      if (wr_en && wr_addr == ADDR_CTL) begin
        xtal_q <= wr_data[1];
        usel_q <= wr_data[2 +: USEL_W];
        if (wr_data[0] && !leave_q && set_blocked) begin
          err_q <= 1'b1;
        end else begin
          leave_q <= wr_data[0];
        end
      end else if (wr_en && wr_addr == ADDR_SYS) begin
        in_sel_q <= wr_data[2:1];
        if (wr_data[0]) begin
          pll_en_q   <= 1'b1;
          off_pend_q <= 1'b0;
        end else if (leave_q || !settled_emg) begin
          leave_q    <= 1'b0;
          off_pend_q <= pll_en_q;
        end else begin
          pll_en_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/clkmode_switch.sv
module clkmode_switch
  import clkmode_pkg::*;
#(
  parameter int NSRC  = 5,
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] target,
  output logic [NSRC-1:0]  clk_en,
  output logic [SRC_W-1:0] cur_src,
  output logic             in_gap,
  output logic             settled_emg
);
  sw_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_STEADY;
      cur_src <= '0;
    end else begin
      unique case (state_q)
        SW_STEADY: if (target != cur_src) state_q <= SW_GAP;
        SW_GAP: begin
          cur_src <= target;
          state_q <= SW_STEADY;
        end
        default: state_q <= SW_STEADY;
      endcase
    end
  end

  assign in_gap      = (state_q == SW_GAP);
  assign settled_emg = !in_gap && (cur_src == '0);

  for (genvar i = 0; i < NSRC; i++) begin : g_en
    assign clk_en[i] = !in_gap && (cur_src == SRC_W'(i));
  end
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int WW          = 4,
  parameter int RW          = 5,
  parameter int NUM_PLL_CLK = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [WW-1:0]        wr_data,
  input  logic [1:0]           rd_addr,
  output logic [RW-1:0]        rd_data,
  input  logic                 pll_lock,
  output logic                 pll_en_o,
  output logic [2:0]           prediv_ratio,
  output logic                 freq_corr,
  output logic                 iom_master_only,
  output logic [NUM_PLL_CLK:0] clk_en
);
  localparam int NSRC   = NUM_PLL_CLK + 1;
  localparam int SRC_W  = $clog2(NSRC);
  localparam int USEL_W = $clog2(NUM_PLL_CLK);

  logic              leave_q;
  logic              xtal_q;
  logic [USEL_W-1:0] usel_q;
  logic [1:0]        in_sel_q;
  logic              err_q;
  logic              settled_emg;
  logic              in_gap;
  logic [SRC_W-1:0]  cur_src;
  logic [SRC_W-1:0]  target;
  prediv_t           pdv;

  clkmode_regs #(.WW(WW), .USEL_W(USEL_W)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .pll_lock, .settled_emg,
    .leave_q, .xtal_q, .usel_q, .pll_en_q(pll_en_o), .in_sel_q, .err_q
  );

  clkmode_prediv u_prediv (.xtal358(xtal_q), .in_sel(in_sel_q), .res(pdv));

  assign target = leave_q ? SRC_W'(usel_q) + SRC_W'(1) : '0;

  clkmode_switch #(.NSRC(NSRC), .SRC_W(SRC_W)) u_switch (
    .clk, .rst_n, .target, .clk_en, .cur_src, .in_gap, .settled_emg
  );

  assign prediv_ratio    = pdv.ratio;
  assign freq_corr       = pdv.corr;
  assign iom_master_only = pdv.corr;

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      ADDR_CTL:  rd_data = RW'({usel_q, xtal_q, leave_q});
      ADDR_SYS:  rd_data = RW'({in_sel_q, pll_en_o});
      ADDR_STAT: rd_data = RW'({err_q, in_gap, cur_src});
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk #(
  parameter int NSRC = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] clk_en,
  input logic            pll_en_o,
  input logic            freq_corr,
  input logic [2:0]      prediv_ratio,
  input logic            leave_q,
  input logic            err_q
);
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clk_en));

  a_r8_no_direct_swap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clk_en) != '0 && clk_en != '0) |-> clk_en == $past(clk_en));

  a_r8_gap_single: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en == '0) |=> (clk_en != '0));

  a_r7_pll_on_for_pll_clk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clk_en[NSRC-1:1]) |-> pll_en_o);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_q) |-> err_q);

  a_r4_emergency_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!leave_q && !$past(leave_q) && !$past(leave_q, 2)) |-> clk_en == NSRC'(1));

  a_r3_corr_ratio_one: assert property (@(posedge clk) disable iff (!rst_n)
    freq_corr |-> prediv_ratio == 3'd1);
endmodule

bind clkmode_ctrl clkmode_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pll_en_o(pll_en_o),
  .freq_corr(freq_corr), .prediv_ratio(prediv_ratio),
  .leave_q(leave_q), .err_q(err_q)
);

// File: tb/tb_clkmode_ctrl.sv
module tb_clkmode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [4:0] rd_data;
  logic       pll_lock = 1'b0;
  logic       pll_en_o;
  logic [2:0] prediv_ratio;
  logic       freq_corr;
  logic       iom_master_only;
  logic [4:0] clk_en;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  clkmode_ctrl dut (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .pll_lock, .pll_en_o, .prediv_ratio, .freq_corr, .iom_master_only, .clk_en
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [1:0] a, input int exp);
    rd_addr = a;
    #1;
    chk(req, $sformatf("read addr %0d", a), int'(rd_data), exp);
  endtask

  task automatic t_reset();
    rdchk("R1", 2'd0, 0);
    rdchk("R1", 2'd1, 0);
    rdchk("R9", 2'd2, 0);
    chk("R1", "clk_en", int'(clk_en), 5'b00001);
    chk("R1", "ratio", int'(prediv_ratio), 1);
    chk("R1", "freq_corr", int'(freq_corr), 0);
    chk("R1", "pll_en_o", int'(pll_en_o), 0);
  endtask

  task automatic t_prediv();
    wr(2'd1, 4'b0010); chk("R2", "ratio sel01", int'(prediv_ratio), 2);
    wr(2'd1, 4'b0100); chk("R2", "ratio sel10", int'(prediv_ratio), 4);
    wr(2'd1, 4'b0110); chk("R2", "ratio sel11", int'(prediv_ratio), 1);
    wr(2'd1, 4'b0000); chk("R2", "ratio sel00", int'(prediv_ratio), 1);
    chk("R2", "no corr", int'(freq_corr), 0);
    wr(2'd0, 4'b0010);
    chk("R3", "ratio 358", int'(prediv_ratio), 1);
    chk("R3", "freq_corr", int'(freq_corr), 1);
    chk("R3", "iom master", int'(iom_master_only), 1);
    wr(2'd1, 4'b0010);
    chk("R3", "ratio 358+sel01", int'(prediv_ratio), 1);
    chk("R3", "corr off 358+sel01", int'(freq_corr), 0);
    wr(2'd1, 4'b0000);
    wr(2'd0, 4'b0000);
  endtask

  task automatic t_emergency();
    wr(2'd0, 4'b1100);
    chk("R4", "en after sel write", int'(clk_en), 5'b00001);
    @(negedge clk); chk("R4", "en +1", int'(clk_en), 5'b00001);
    @(negedge clk); chk("R4", "en +2", int'(clk_en), 5'b00001);
  endtask

  task automatic t_guard();
    wr(2'd0, 4'b0101);
    rdchk("R6", 2'd0, 5'b00100);
    rdchk("R6", 2'd2, 5'b10000);
    @(negedge clk); chk("R6", "en stays emg", int'(clk_en), 5'b00001);
    wr(2'd1, 4'b0001);
    chk("R7", "pll_en on", int'(pll_en_o), 1);
    pll_lock = 1'b0;
    wr(2'd0, 4'b0001);
    rdchk("R6", 2'd0, 0);
    pll_lock = 1'b1;
    wr(2'd0, 4'b0001);
    rdchk("R10", 2'd0, 1);
    rdchk("R10", 2'd2, 5'b10000);
    @(negedge clk);
    chk("R8", "gap", int'(clk_en), 0);
    rdchk("R9", 2'd2, 5'b11000);
    @(negedge clk);
    chk("R5", "sel00 clock", int'(clk_en), 5'b00010);
    rdchk("R9", 2'd2, 5'b10001);
  endtask

  task automatic t_switch();
    wr(2'd0, 4'b1001);
    chk("R8", "old still on", int'(clk_en), 5'b00010);
    @(negedge clk); chk("R8", "gap 10", int'(clk_en), 0);
    @(negedge clk); chk("R5", "sel10 clock", int'(clk_en), 5'b01000);
    wr(2'd0, 4'b0101);
    @(negedge clk); chk("R8", "gap 01", int'(clk_en), 0);
    @(negedge clk); chk("R5", "sel01 clock", int'(clk_en), 5'b00100);
    wr(2'd0, 4'b1101);
    @(negedge clk); chk("R8", "gap 11", int'(clk_en), 0);
    @(negedge clk); chk("R5", "sel11 clock", int'(clk_en), 5'b10000);
  endtask

  task automatic t_pll_off();
    wr(2'd1, 4'b0100);
    rdchk("R7", 2'd0, 5'b01100);
    chk("R7", "pll held", int'(pll_en_o), 1);
    chk("R7", "in_sel applied", int'(prediv_ratio), 4);
    @(negedge clk);
    chk("R7", "gap en", int'(clk_en), 0);
    chk("R7", "pll held gap", int'(pll_en_o), 1);
    @(negedge clk);
    chk("R7", "back to emg", int'(clk_en), 5'b00001);
    chk("R7", "pll held emg", int'(pll_en_o), 1);
    @(negedge clk);
    chk("R7", "pll off", int'(pll_en_o), 0);
    rdchk("R10", 2'd2, 5'b10000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prediv();
    t_emergency();
    t_guard();
    t_switch();
    t_pll_off();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule